// File: doc/BRIEF.md
# PLL Coast Window Generator

This block drives the coast input of a line-locked clock-recovery PLL. While coast is active the PLL holds its phase and frequency and ignores horizontal sync edges. Around the vertical sync interval those edges are irregular because of equalization and serration pulses, so the PLL must not follow them. The window covers the vertical sync interval. It can open a programmable number of line periods before vertical sync starts, and it can stay open a programmable number of line periods after vertical sync ends.

The block cannot see the next vertical sync in advance. It therefore measures the frame length in line ticks and opens the early part of the window when the line count comes within the programmed distance of that length. The output polarity is active high by default. A user setting can select either polarity instead. All inputs are synchronous to `clk_i`. The line input is a one-cycle tick per line, and vertical sync is a level, active high.

Top module: `coast_window_gen`

## Requirements
- R1: While `rst_ni` is low, `coast_o` is 0.
- R2: With both counts at 0 and `pol_ovr_i` at 0, `coast_o` is 1 exactly while `vsync_i` is high, delayed by two clock cycles at each edge.
- R3: With a post count N, the window stays open after `vsync_i` falls and closes at the N-th line tick after the fall. N = 0 adds nothing. A tick in the same cycle as the fall is not counted.
- R4: The frame length F is the number of line ticks between two consecutive rising edges of `vsync_i`. The line count c is the number of ticks since the latest rising edge, and a tick in the same cycle as that edge is not counted. With a pre count P > 0, the window is open while c + P > F. The output follows one clock after the tick that makes this true.
- R5: Until two rising edges of `vsync_i` have been seen since reset, the pre count has no effect.
- R6: F is measured again at every rising edge of `vsync_i`. A changed frame length therefore takes effect on the pre window of the frame that follows it.
- R7: `pol_ovr_i` = 0 gives an active-high output. With `pol_ovr_i` = 1, `pol_usr_i` = 1 gives an active-high output and `pol_usr_i` = 0 gives an active-low (inverted) output.
- R8: A pre count of F or more keeps the window open for the whole frame once F is known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_tick_i | input | 1 | One-cycle pulse per line |
| vsync_i | input | 1 | Vertical sync level, active high |
| pre_cnt_i | input | CNT_W | Lines of coast before vertical sync |
| post_cnt_i | input | CNT_W | Lines of coast after vertical sync |
| pol_ovr_i | input | 1 | 1 selects the user polarity |
| pol_usr_i | input | 1 | User polarity, 1 = active high |
| coast_o | output | 1 | Coast window with polarity applied |

## Verification
A wrong line count or frame length shows first as a pre window that opens on the wrong line of the next full frame. A missing frame-valid gate shows on the first frame after reset. A post counter that loads or counts wrongly moves the closing line of the window within a few lines of the falling edge of vertical sync. A polarity error shows on every sampled line.

The bench samples `coast_o` once per line at the end of the line. Any misplaced edge of the window is therefore seen within one line period, and every expected value follows from line numbers and the counts.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic {
    POL_AUTO = 1'b0,
    POL_USER = 1'b1
  } pol_src_e;
endpackage

// File: rtl/cw_line_meter.sv
module cw_line_meter #(
  parameter int LINE_W = 11,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_tick_i,
  input  logic             vs_rise_i,
  input  logic [CNT_W-1:0] pre_cnt_i,
  output logic             pre_on_o
);
  localparam int SUM_W = ((LINE_W > CNT_W) ? LINE_W : CNT_W) + 1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q, flen_q;
  logic              seen_q, vld_q;
  logic [SUM_W-1:0]  reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      flen_q <= '0;
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (vs_rise_i) begin
      line_q <= '0;
      seen_q <= 1'b1;
      if (seen_q) begin
        flen_q <= line_q;
        vld_q  <= 1'b1;
      end
    end else if (hs_tick_i && line_q != LINE_MAX) begin
      line_q <= line_q + 1'b1;
    end
  end

  // window opens when lines-so-far plus pre distance passes the last frame length
  assign reach    = SUM_W'(line_q) + SUM_W'(pre_cnt_i);
  assign pre_on_o = vld_q && (pre_cnt_i != '0) && (reach > SUM_W'(flen_q));

  AST_FRAME_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise_i && seen_q) |=> (vld_q && flen_q == $past(line_q))); // R6
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_tick_i && !vs_rise_i && line_q != LINE_MAX) |=> (line_q == $past(line_q) + 1'b1)); // R4
  AST_LINE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise_i |=> (line_q == '0)); // R4
endmodule

// File: rtl/cw_post_timer.sv
module cw_post_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_tick_i,
  input  logic             vs_fall_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  output logic             post_on_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (vs_fall_i)                 cnt_q <= post_cnt_i;
    else if (hs_tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign post_on_o = (cnt_q != '0);

  AST_POST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall_i |=> (cnt_q == $past(post_cnt_i))); // R3
  AST_POST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_tick_i && !vs_fall_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/cw_pol_out.sv
module cw_pol_out
  import cw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic window_i,
  input  logic pol_ovr_i,
  input  logic pol_usr_i,
  output logic coast_o
);
  pol_src_e src;
  logic     invert;

  assign src    = pol_ovr_i ? POL_USER : POL_AUTO;
  assign invert = (src == POL_USER) && !pol_usr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coast_o <= 1'b0;
    else         coast_o <= window_i ^ invert;
  end
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen #(
  parameter int CNT_W  = 8,
  parameter int LINE_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_tick_i,
  input  logic             vsync_i,
  input  logic [CNT_W-1:0] pre_cnt_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  input  logic             pol_ovr_i,
  input  logic             pol_usr_i,
  output logic             coast_o
);
  logic vs_q, vs_rise, vs_fall;
  logic pre_on, post_on, window;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= vsync_i;
  end

  assign vs_rise = vsync_i && !vs_q;
  assign vs_fall = !vsync_i && vs_q;

  cw_line_meter #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_tick_i (hs_tick_i),
    .vs_rise_i (vs_rise),
    .pre_cnt_i (pre_cnt_i),
    .pre_on_o  (pre_on)
  );

  cw_post_timer #(.CNT_W(CNT_W)) u_post (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hs_tick_i  (hs_tick_i),
    .vs_fall_i  (vs_fall),
    .post_cnt_i (post_cnt_i),
    .post_on_o  (post_on)
  );

  // registered vsync keeps the post window contiguous with the vsync window
  assign window = vs_q | pre_on | post_on;

  cw_pol_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .window_i  (window),
    .pol_ovr_i (pol_ovr_i),
    .pol_usr_i (pol_usr_i),
    .coast_o   (coast_o)
  );

  AST_VS_COVERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_q && !pol_ovr_i) |=> coast_o); // R2
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vs_q && !pre_on && !post_on && !pol_ovr_i) |=> !coast_o); // R2
  AST_USER_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_ovr_i && !pol_usr_i && vs_q) |=> !coast_o); // R7
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> !coast_o); // R1
endmodule

// File: tb/coast_window_gen_test.sv
module coast_window_gen_test;
  localparam int VSW   = 3;
  localparam int LCYC  = 8;
  localparam int NVEC  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_tick = 1'b0;
  logic       vsync = 1'b0;
  logic [7:0] pre_cnt = '0;
  logic [7:0] post_cnt = '0;
  logic       pol_ovr = 1'b0;
  logic       pol_usr = 1'b0;
  logic       coast;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  coast_window_gen uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .hs_tick_i  (hs_tick),
    .vsync_i    (vsync),
    .pre_cnt_i  (pre_cnt),
    .post_cnt_i (post_cnt),
    .pol_ovr_i  (pol_ovr),
    .pol_usr_i  (pol_usr),
    .coast_o    (coast)
  );

  // {pre, post, override, user}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'd4, 8'd2, 1'b0, 1'b0},
    {8'd0, 8'd0, 1'b0, 1'b0},
    {8'd0, 8'd1, 1'b0, 1'b0},
    {8'd0, 8'd5, 1'b0, 1'b0},
    {8'd3, 8'd0, 1'b0, 1'b0},
    {8'd1, 8'd2, 1'b0, 1'b0},
    {8'd3, 8'd2, 1'b1, 1'b0},
    {8'd2, 8'd3, 1'b1, 1'b1}
  };

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (coast !== exp) begin
      n_fail++;
      $display("FAIL %s: coast_o actual %b expected %b at %0t", tag, coast, exp, $time);
    end
  endtask

  function automatic logic exp_coast(int j, int fl, bit vld, int p, int n, bit ovr, bit usr);
    logic a;
    a = (j < VSW) || (j >= VSW && (j - VSW + 1) < n) || (vld && p > 0 && (j + 1 + p) > fl);
    return ovr ? (usr ? a : ~a) : a;
  endfunction

  task automatic do_line(input logic vs, input logic chk, input logic exp, input string tag);
    for (int c = 0; c < LCYC; c++) begin
      @(negedge clk);
      if (c == LCYC - 1 && chk) check(exp, tag);
      if (c == 0) vsync = vs;
      hs_tick = (c == 3);
    end
  endtask

  task automatic run_frame(input int lines, input int fl, input bit vld, input int p,
                           input int n, input bit ovr, input bit usr, input string tag);
    pre_cnt  = 8'(p);
    post_cnt = 8'(n);
    pol_ovr  = ovr;
    pol_usr  = usr;
    for (int j = 0; j < lines; j++)
      do_line(j < VSW, 1'b1, exp_coast(j, fl, vld, p, n, ovr, usr), tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset");
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) do_line(1'b0, 1'b1, 1'b0, "R1 idle");

    // table walk, frame length 16
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      int p, n;
      bit ovr, usr;
      p   = int'(VEC[i][17:10]);
      n   = int'(VEC[i][9:2]);
      ovr = VEC[i][1];
      usr = VEC[i][0];
      if (i == 0)      tag = "R5 first frame";
      else if (ovr)    tag = "R7 polarity";
      else if (p != 0) tag = "R4 pre";
      else if (n != 0) tag = "R3 post";
      else             tag = "R2 vsync only";
      run_frame(16, 16, i != 0, p, n, ovr, usr, tag);
    end

    // frame length change: old length still in use for one frame
    run_frame(12, 16, 1'b1, 2, 0, 1'b0, 1'b0, "R6 old length");
    run_frame(12, 12, 1'b1, 2, 0, 1'b0, 1'b0, "R6 new length");
    run_frame(12, 12, 1'b1, 255, 0, 1'b0, 1'b0, "R8 pre over frame");

    // reset in mid-operation with inverting polarity selected
    @(negedge clk);
    rst_n = 1'b0;
    vsync = 1'b0;
    hs_tick = 1'b0;
    pol_ovr = 1'b1;
    pol_usr = 1'b0;
    #1;
    check(1'b0, "R1 async reset");
    repeat (3) @(negedge clk);
    check(1'b0, "R1 held reset");
    rst_n = 1'b1;
    pol_ovr = 1'b0;
    for (int k = 0; k < 3; k++) do_line(1'b0, 1'b1, 1'b0, "R1 after reset");
    run_frame(16, 16, 1'b0, 4, 0, 1'b0, 1'b0, "R5 after reset");
    run_frame(16, 16, 1'b1, 4, 0, 1'b0, 1'b0, "R4 after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule